// File: doc/BRIEF.md
# Conditional relative branch unit

This block decides whether a short relative jump is taken and produces the program counter that follows it. It receives the low nibble of the branch opcode, a flag telling whether an alternate-meaning prefix came before it, the six condition flags (carry, zero, negative, overflow, half-carry, interrupt mask), the level of an external interrupt line, the address of the next sequential instruction and a signed 8-bit displacement.

In every cycle the condition for the selected code is evaluated and, in parallel, a branch target is formed by sign-extending the displacement and adding it to the sequential address modulo 2^PC_W. The taken flag and the chosen next address are registered, so they appear one clock after the inputs. When the prefix is present, three condition pairs are given new meanings: one tests the half-carry flag, one the interrupt mask and one the external interrupt line. The block does not fetch instruction bytes and has no part in calls or returns.

Top module: `brc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `br_taken`=0 and `br_pc`=0.
- R2: Condition code 0x0 is always taken and code 0x1 is never taken, with or without the prefix.
- R3: Code 0x2 is taken when C=0 and Z=0; code 0x3 is taken when C=1 or Z=1.
- R4: Without the prefix, codes 0x4/0x5 are taken for C clear/set, 0x6/0x7 for Z clear/set, 0x8/0x9 for V clear/set and 0xA/0xB for N clear/set.
- R5: Without the prefix, code 0xC is taken when Z=0 and N equals V; code 0xD is taken when Z=1 or N differs from V.
- R6: Without the prefix, code 0xE is taken when N equals V; code 0xF is taken when N differs from V.
- R7: With the prefix, codes 0x8/0x9 are taken for the half-carry flag clear/set, and V has no effect on them.
- R8: With the prefix, codes 0xC/0xD are taken for the interrupt mask clear/set.
- R9: With the prefix, codes 0xE/0xF are taken when the external interrupt line is low/high.
- R10: The prefix has no effect on codes 0x0 to 0x7, 0xA and 0xB.
- R11: When taken, `br_pc` equals the sequential address plus the displacement sign-extended to PC_W bits, wrapping modulo 2^PC_W.
- R12: When not taken, `br_pc` equals the sequential address.
- R13: Both outputs reflect the inputs present at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 4 | Low nibble of the branch opcode (condition code) |
| alt_pfx | input | 1 | Alternate-meaning prefix present |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| irq_level | input | 1 | Level of the external interrupt line |
| seq_pc | input | PC_W (24) | Address of the next sequential instruction |
| rel_off | input | OFF_W (8) | Signed displacement |
| br_taken | output | 1 | Registered taken decision |
| br_pc | output | PC_W (24) | Registered next program counter |

## Verification
The prefix remapping of a condition and a target that wraps past the top or bottom of the address space can fall in the same cycle, since the decision and the addition are done side by side. The bench provokes this by issuing a prefixed interrupt-line or half-carry branch that is taken with a sequential address near 0xFFFFFF and a positive displacement, and again near zero with a negative one. It then drives the same pair with the opposite flag so that the sequential address must appear instead. Each cycle is judged against a behavioural model that computes the decision from a case on the code and the target with integer arithmetic reduced modulo 2^24.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic h;
    logic i;
  } brc_flags_t;

  typedef enum logic [3:0] {
    CS_ALWAYS = 4'h0,
    CS_NEVER  = 4'h1,
    CS_UGT    = 4'h2,
    CS_ULE    = 4'h3,
    CS_CCLR   = 4'h4,
    CS_CSET   = 4'h5,
    CS_ZCLR   = 4'h6,
    CS_ZSET   = 4'h7,
    CS_VCLR   = 4'h8,
    CS_VSET   = 4'h9,
    CS_NCLR   = 4'hA,
    CS_NSET   = 4'hB,
    CS_SGT    = 4'hC,
    CS_SLE    = 4'hD,
    CS_SGE    = 4'hE,
    CS_SLT    = 4'hF
  } brc_code_t;

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0]  code,
  input  logic        pfx,
  input  brc_flags_t  flg,
  input  logic        irq,
  output logic        hit
);

  // Each pair shares a base test; the odd code is its inverse.
  logic base_test;
  logic signs_agree;

  assign signs_agree = (flg.n == flg.v);

  always_comb begin
    base_test = 1'b0;
    unique case (code[3:1])
      3'd0: base_test = 1'b1;
      3'd1: base_test = ~flg.c & ~flg.z;
      3'd2: base_test = ~flg.c;
      3'd3: base_test = ~flg.z;
      3'd4: base_test = pfx ? ~flg.h : ~flg.v;
      3'd5: base_test = ~flg.n;
      3'd6: base_test = pfx ? ~flg.i : (~flg.z & signs_agree);
      3'd7: base_test = pfx ? ~irq : signs_agree;
      default: base_test = 1'b0;
    endcase
  end

  assign hit = code[0] ? ~base_test : base_test;

endmodule

// File: rtl/brc_target_add.sv
module brc_target_add #(
  parameter int PC_W  = 24,
  parameter int OFF_W = 8
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  target
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
  endgenerate

  // Carry out of the top bit is dropped: address wraps modulo 2^PC_W.
  assign target = base + off_ext;

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int PC_W  = 24,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       cond_sel,
  input  logic             alt_pfx,
  input  logic             flag_c,
  input  logic             flag_z,
  input  logic             flag_n,
  input  logic             flag_v,
  input  logic             flag_h,
  input  logic             flag_i,
  input  logic             irq_level,
  input  logic [PC_W-1:0]  seq_pc,
  input  logic [OFF_W-1:0] rel_off,
  output logic             br_taken,
  output logic [PC_W-1:0]  br_pc
);

  brc_flags_t      flags;
  logic            cond_hit;
  logic [PC_W-1:0] jump_pc;
  logic [PC_W-1:0] pick_pc;

  assign flags = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v,
                   h: flag_h, i: flag_i};

  brc_cond_eval u_cond (
    .code (cond_sel),
    .pfx  (alt_pfx),
    .flg  (flags),
    .irq  (irq_level),
    .hit  (cond_hit)
  );

  brc_target_add #(.PC_W(PC_W), .OFF_W(OFF_W)) u_add (
    .base   (seq_pc),
    .off    (rel_off),
    .target (jump_pc)
  );

  assign pick_pc = cond_hit ? jump_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      br_taken <= 1'b0;
      br_pc    <= '0;
    end else begin
      br_taken <= cond_hit;
      br_pc    <= pick_pc;
    end
  end

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int PC_W  = 24,
  parameter int OFF_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       cond_sel,
  input logic             alt_pfx,
  input logic             flag_c,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_v,
  input logic             flag_h,
  input logic             flag_i,
  input logic             irq_level,
  input logic [PC_W-1:0]  seq_pc,
  input logic [OFF_W-1:0] rel_off,
  input logic             br_taken,
  input logic [PC_W-1:0]  br_pc
);

  localparam int EXT_W = PC_W - OFF_W;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!br_taken && br_pc == '0));

  assert_always_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_sel) == 4'h0) |-> br_taken);

  assert_never_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_sel) == 4'h1) |-> !br_taken);

  assert_unsigned_gt_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_sel) == 4'h2)
      |-> br_taken == (!$past(flag_c) && !$past(flag_z)));

  assert_carry_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(alt_pfx) && $past(cond_sel) == 4'h5)
      |-> br_taken == $past(flag_c));

  assert_signed_ge_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(alt_pfx) && $past(cond_sel) == 4'hE)
      |-> br_taken == ($past(flag_n) == $past(flag_v)));

  assert_half_set_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alt_pfx) && $past(cond_sel) == 4'h9)
      |-> br_taken == $past(flag_h));

  assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alt_pfx) && $past(cond_sel) == 4'hD)
      |-> br_taken == $past(flag_i));

  assert_line_low_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alt_pfx) && $past(cond_sel) == 4'hE)
      |-> br_taken == !$past(irq_level));

  assert_target_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && br_taken)
      |-> br_pc == $past(seq_pc)
                 + {{EXT_W{$past(rel_off[OFF_W-1])}}, $past(rel_off)});

  assert_fallthru_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !br_taken) |-> br_pc == $past(seq_pc));

endmodule

bind brc_unit brc_unit_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .cond_sel(cond_sel), .alt_pfx(alt_pfx),
  .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
  .flag_h(flag_h), .flag_i(flag_i), .irq_level(irq_level),
  .seq_pc(seq_pc), .rel_off(rel_off), .br_taken(br_taken), .br_pc(br_pc)
);

// File: tb/brc_unit_bench.sv
`timescale 1ns/1ps
module brc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cond_sel = '0;
  logic        alt_pfx = 1'b0;
  logic        flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0;
  logic        flag_h = 0, flag_i = 0, irq_level = 0;
  logic [23:0] seq_pc = '0;
  logic [7:0]  rel_off = '0;
  logic        br_taken;
  logic [23:0] br_pc;

  integer total = 0;
  integer bad = 0;
  bit     done = 0;

  always #2.5 clk = ~clk;

  brc_unit u_brc_unit (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .alt_pfx(alt_pfx),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
    .flag_h(flag_h), .flag_i(flag_i), .irq_level(irq_level),
    .seq_pc(seq_pc), .rel_off(rel_off), .br_taken(br_taken), .br_pc(br_pc)
  );

  // Behavioural model of the decision.
  function automatic bit model_take(input int code, input bit p,
      input bit c, input bit z, input bit n, input bit v,
      input bit h, input bit im, input bit q);
    case (code)
      0:  return 1;
      1:  return 0;
      2:  return (c == 0) && (z == 0);
      3:  return (c == 1) || (z == 1);
      4:  return c == 0;
      5:  return c == 1;
      6:  return z == 0;
      7:  return z == 1;
      8:  return p ? (h == 0) : (v == 0);
      9:  return p ? (h == 1) : (v == 1);
      10: return n == 0;
      11: return n == 1;
      12: return p ? (im == 0) : ((z == 0) && (n == v));
      13: return p ? (im == 1) : ((z == 1) || (n != v));
      14: return p ? (q == 0) : (n == v);
      default: return p ? (q == 1) : (n != v);
    endcase
  endfunction

  function automatic string req_of(input int code, input bit p);
    if (p && (code == 8 || code == 9))   return "R7";
    if (p && (code == 12 || code == 13)) return "R8";
    if (p && (code == 14 || code == 15)) return "R9";
    if (p)                               return "R10";
    if (code < 2)  return "R2";
    if (code < 4)  return "R3";
    if (code < 12) return "R4";
    if (code < 14) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one set of inputs at a falling edge; the outputs are compared one
  // rising edge later, at the next falling edge (R13: one cycle of latency).
  task automatic step(input int code, input bit p, input bit c, input bit z,
      input bit n, input bit v, input bit h, input bit im, input bit q,
      input int pc, input int d);
    bit exp_t;
    int disp_s;
    longint exp_pc;
    cond_sel = code[3:0]; alt_pfx = p;
    flag_c = c; flag_z = z; flag_n = n; flag_v = v;
    flag_h = h; flag_i = im; irq_level = q;
    seq_pc = pc[23:0]; rel_off = d[7:0];
    exp_t = model_take(code, p, c, z, n, v, h, im, q);
    disp_s = (d[7:0] >= 128) ? int'(d[7:0]) - 256 : int'(d[7:0]);
    if (exp_t) exp_pc = (longint'(pc[23:0]) + disp_s + 64'h1000000) % 64'h1000000;
    else       exp_pc = longint'(pc[23:0]);
    @(negedge clk);
    check({req_of(code, p), "/R13 taken"}, br_taken, exp_t);
    check(exp_t ? "R11 pc" : "R12 pc", br_pc, exp_pc);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset held while inputs would make a taken branch
    cond_sel = 4'h0; seq_pc = 24'h123456; rel_off = 8'h10;
    repeat (3) @(negedge clk);
    check("R1 taken", br_taken, 0);
    check("R1 pc", br_pc, 0);
    rst = 1'b0;

    // R2 with and without prefix
    step(0, 0, 0,0,0,0,0,0,0, 24'h000100, 8'h05);
    step(1, 0, 1,1,1,1,1,1,1, 24'h000100, 8'h05);
    step(0, 1, 0,0,0,0,0,0,0, 24'h000200, 8'hFE);
    step(1, 1, 0,0,0,0,0,0,0, 24'h000200, 8'hFE);
    // R3
    step(2, 0, 0,0,0,0,0,0,0, 24'h001000, 8'h7F);
    step(2, 0, 0,1,0,0,0,0,0, 24'h001000, 8'h7F);
    step(3, 0, 1,0,0,0,0,0,0, 24'h001000, 8'h80);
    step(3, 0, 0,0,0,0,0,0,0, 24'h001000, 8'h80);
    // R4: V pair unprefixed, half-carry set must not matter
    step(9, 0, 0,0,0,1,0,0,0, 24'h002000, 8'h01);
    step(8, 0, 0,0,0,1,1,0,0, 24'h002000, 8'h01);
    step(11, 0, 0,0,1,0,0,0,0, 24'h002000, 8'h01);
    // R5 / R6
    step(12, 0, 0,0,1,1,0,0,0, 24'h003000, 8'h10);
    step(12, 0, 0,1,1,1,0,0,0, 24'h003000, 8'h10);
    step(13, 0, 0,0,1,0,0,0,0, 24'h003000, 8'h10);
    step(14, 0, 0,1,0,0,0,0,0, 24'h003000, 8'h10);
    step(15, 0, 0,0,0,1,0,0,0, 24'h003000, 8'h10);
    // R7: prefix, V set but H clear -> code 9 not taken
    step(9, 1, 0,0,0,1,0,0,0, 24'h004000, 8'h20);
    step(8, 1, 0,0,0,1,0,0,0, 24'h004000, 8'h20);
    // R8
    step(13, 1, 0,0,0,0,0,1,0, 24'h005000, 8'h30);
    step(12, 1, 0,1,1,0,0,1,0, 24'h005000, 8'h30);
    // R9 combined with wrap (R11) and fall-through (R12)
    step(15, 1, 0,0,0,0,0,0,1, 24'hFFFFF0, 8'h20);
    step(15, 1, 0,0,0,0,0,0,0, 24'hFFFFF0, 8'h20);
    step(14, 1, 0,0,0,0,0,0,0, 24'h000005, 8'hF0);
    step(8, 1, 0,0,0,0,0,0,0, 24'h000003, 8'h80);
    // R10: prefix on unaffected codes
    step(5, 1, 1,0,0,0,0,0,0, 24'h006000, 8'h08);
    step(10, 1, 0,0,1,0,1,1,1, 24'h006000, 8'h08);

    // Mixed patterns
    for (int k = 0; k < 3000; k++) begin
      automatic int r = $urandom;
      step(r & 15, r[4], r[5], r[6], r[7], r[8], r[9], r[10], r[11],
           int'($urandom) & 24'hFFFFFF, int'($urandom) & 8'hFF);
    end

    // R1 again mid-run
    rst = 1'b1;
    cond_sel = 4'h0;
    @(negedge clk);
    check("R1 taken", br_taken, 0);
    check("R1 pc", br_pc, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule